// File: doc/BRIEF.md
# I2C-Addressed Pin Control Bank

This block is an I2C target that gives a host byte-wide access to a bank of general-purpose pins and a few signal-routing controls. To write, the host addresses the block, sends a 16-bit register pointer as two bytes (high byte first), and then sends one data byte. To read, the host sends the pointer the same way, issues a repeated start with the read bit set, clocks one byte back, and ends with a NACK. The pointer does not advance.

Each pin has its own register. Bit 0 is the output enable, bit 1 is the output value, and bit 2 is the pad level after synchronization. Three more registers hold two 3-bit UART routing selectors and one bit that hands a chosen output pin over to an incoming PWM signal.

SCL and SDA are oversampled on the system clock, synchronized and glitch-filtered. START and STOP are recognized as SDA edges while SCL is high. The block pulls SDA low only during its ACK bits and the zero bits of read data. The block never stretches the clock.

Top module: `i2c_gpio_bank`

## Requirements
- R1: The block ACKs any 7-bit target address in the range 0x28 to 0x2F, whatever its three low bits are. Every address outside that range gets no ACK, and SDA stays released.
- R2: A write is the target address with R/W = 0, then pointer high byte, then pointer low byte, then one data byte. The block ACKs every one of these bytes.
- R3: A read is a pointer write followed by a repeated start and the target address with R/W = 1. The block returns the addressed register MSB first and releases SDA when the host NACKs.
- R4: For pins 0 to 29, register n bit 0 drives `pin_oe[n]` and bit 1 drives `pin_o[n]`. Both bits read back as written.
- R5: Bit 2 of any pin register reads `pin_i[n]` through a two-flop synchronizer. Bits 7:3 of pin registers always read as 0, even after writing ones to them.
- R6: Pins 30 to 43 never drive. Their `pin_oe` and `pin_o` stay 0, and register bits 1:0 for them read 0 after any write.
- R7: Register 307 bits 2:0 set `uart_sel_a`, and register 308 bits 2:0 set `uart_sel_b`. Both reset to 0 and read back in bits 2:0 with bits 7:3 zero.
- R8: Register 309 bit 0 set to 1 puts pin `PWM_PIN` (default 22) under PWM control: `pin_o` follows `pwm_i` and `pin_oe` is 1. Clearing the bit returns the pin to its own register.
- R9: Registers 44 to 306 and above 309 read 0x00. Writes to them change no output, and all bytes of such a transaction are still ACKed.
- R10: After reset all pin outputs, enables and selectors are 0 and SDA is released. SDA is pulled low only in ACK slots and read-data bits.
- R11: A pulse on SDA or SCL shorter than `FILT` system clocks is ignored. In particular, an SDA glitch while SCL is high does not create a START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sampled SCL line |
| sda_i | input | 1 | Sampled SDA line |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| pin_i | input | 44 | Pad levels of the pin bank |
| pin_o | output | 44 | Output values for the pin bank |
| pin_oe | output | 44 | Output enables for the pin bank |
| pwm_i | input | 1 | PWM source that can be routed to `PWM_PIN` |
| uart_sel_a | output | 3 | Routing selector for the modem port |
| uart_sel_b | output | 3 | Routing selector for the header port |

## Verification
Each bus line passes through two synchronizer flops and a three-sample filter, so the block sees an SCL edge about six clocks after the host makes it. Both the ACK drive and the register update land around six clocks after the SCL fall that closes a byte. The bench model therefore holds each SCL phase for eight clocks. It samples SDA one phase after its own SCL rise, and it checks pin outputs and selectors only after the STOP, when any register write is long complete. Read data is latched when the block ACKs the read address. Bit 2 must follow `pin_i` within two clocks, so the bench changes pad inputs several bit times before it starts the read that observes them.

// File: rtl/i2c_gpio_bank.sv
module i2c_gpio_bank #(
  parameter int NPINS = 44,
  parameter int NOUT = 30,
  parameter logic [6:0] DEV_BASE = 7'h28,
  parameter int REG_SEL_A = 307,
  parameter int REG_SEL_B = 308,
  parameter int REG_PWM = 309,
  parameter int PWM_PIN = 22,
  parameter int SELW = 3,
  parameter int FILT = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe,
  input  logic [NPINS-1:0] pin_i,
  output logic [NPINS-1:0] pin_o,
  output logic [NPINS-1:0] pin_oe,
  input  logic             pwm_i,
  output logic [SELW-1:0]  uart_sel_a,
  output logic [SELW-1:0]  uart_sel_b
);

  typedef enum logic [2:0] {S_IDLE, S_RX, S_ACK, S_TX, S_RACK} st_t;
  typedef enum logic [2:0] {PH_DEV, PH_AH, PH_AL, PH_WD, PH_RD, PH_IGN} ph_t;

  logic [1:0]      scl_m, sda_m;
  logic [FILT-1:0] scl_h, sda_h;
  logic            scl_f, sda_f, scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_m <= '1; sda_m <= '1;
      scl_h <= '1; sda_h <= '1;
      scl_f <= 1'b1; sda_f <= 1'b1;
      scl_p <= 1'b1; sda_p <= 1'b1;
    end else begin
      scl_m <= {scl_m[0], scl_i};
      sda_m <= {sda_m[0], sda_i};
      scl_h <= {scl_h[FILT-2:0], scl_m[1]};
      sda_h <= {sda_h[FILT-2:0], sda_m[1]};
      if (&scl_h) scl_f <= 1'b1;
      else if (~|scl_h) scl_f <= 1'b0;
      if (&sda_h) sda_f <= 1'b1;
      else if (~|sda_h) sda_f <= 1'b0;
      scl_p <= scl_f;
      sda_p <= sda_f;
    end
  end

  wire scl_rise = scl_f & ~scl_p;
  wire scl_fall = ~scl_f & scl_p;
  wire bus_start = scl_f & scl_p & sda_p & ~sda_f;
  wire bus_stop = scl_f & scl_p & ~sda_p & sda_f;

  st_t         st;
  ph_t         ph;
  logic [3:0]  cnt;
  logic [7:0]  sr, tx, rdata;
  logic [15:0] ptr;
  logic        acked;

  logic [NOUT-1:0]  oe_q, out_q;
  logic [NPINS-1:0] in_m, in_s;
  logic             pwm_en;

  wire byte_done = (st == S_RX) && scl_fall && (cnt == 4'd8);
  wire dev_hit = (sr[7:4] == DEV_BASE[6:3]);
  wire wr_en = byte_done && (ph == PH_WD);

  always_comb begin
    rdata = 8'h00;
    for (int i = 0; i < NPINS; i++)
      if (ptr == 16'(i)) rdata[2] = in_s[i];
    for (int i = 0; i < NOUT; i++)
      if (ptr == 16'(i)) rdata[1:0] = {out_q[i], oe_q[i]};
    if (ptr == 16'(REG_SEL_A)) rdata = {{(8-SELW){1'b0}}, uart_sel_a};
    if (ptr == 16'(REG_SEL_B)) rdata = {{(8-SELW){1'b0}}, uart_sel_b};
    if (ptr == 16'(REG_PWM))   rdata = {7'b0, pwm_en};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      ph <= PH_DEV;
      cnt <= '0;
      sr <= '0;
      tx <= '0;
      ptr <= '0;
      acked <= 1'b0;
    end else if (bus_start) begin
      st <= S_RX;
      ph <= PH_DEV;
      cnt <= '0;
    end else if (bus_stop) begin
      st <= S_IDLE;
    end else begin
      case (st)
        S_RX: begin
          if (scl_rise) begin
            sr <= {sr[6:0], sda_f};
            cnt <= cnt + 4'd1;
          end else if (byte_done) begin
            st <= S_ACK;
            case (ph)
              PH_DEV: begin
                if (!dev_hit) st <= S_IDLE;
                else if (sr[0]) begin
                  ph <= PH_RD;
                  tx <= rdata;
                end else ph <= PH_AH;
              end
              PH_AH: begin
                ptr[15:8] <= sr;
                ph <= PH_AL;
              end
              PH_AL: begin
                ptr[7:0] <= sr;
                ph <= PH_WD;
              end
              default: ph <= PH_IGN;
            endcase
          end
        end
        S_ACK: begin
          if (scl_fall) begin
            cnt <= '0;
            st <= (ph == PH_RD) ? S_TX : S_RX;
          end
        end
        S_TX: begin
          if (scl_rise) cnt <= cnt + 4'd1;
          else if (scl_fall) begin
            if (cnt == 4'd8) st <= S_RACK;
            else tx <= {tx[6:0], 1'b0};
          end
        end
        S_RACK: begin
          if (scl_rise) acked <= ~sda_f;
          else if (scl_fall) begin
            if (acked) begin
              tx <= rdata;
              cnt <= '0;
              st <= S_TX;
            end else st <= S_IDLE;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_q <= '0;
      out_q <= '0;
      uart_sel_a <= '0;
      uart_sel_b <= '0;
      pwm_en <= 1'b0;
      in_m <= '0;
      in_s <= '0;
    end else begin
      in_m <= pin_i;
      in_s <= in_m;
      for (int i = 0; i < NOUT; i++)
        if (wr_en && ptr == 16'(i)) begin
          oe_q[i] <= sr[0];
          out_q[i] <= sr[1];
        end
      if (wr_en && ptr == 16'(REG_SEL_A)) uart_sel_a <= sr[SELW-1:0];
      if (wr_en && ptr == 16'(REG_SEL_B)) uart_sel_b <= sr[SELW-1:0];
      if (wr_en && ptr == 16'(REG_PWM)) pwm_en <= sr[0];
    end
  end

  assign sda_oe = (st == S_ACK) || (st == S_TX && !tx[7]);

  always_comb begin
    pin_oe = '0;
    pin_o = '0;
    pin_oe[NOUT-1:0] = oe_q;
    pin_o[NOUT-1:0] = out_q;
    if (pwm_en) begin
      pin_oe[PWM_PIN] = 1'b1;
      pin_o[PWM_PIN] = pwm_i;
    end
  end

endmodule

// File: rtl/i2c_gpio_bank_chk.sv
module i2c_gpio_bank_chk #(
  parameter int NPINS = 44,
  parameter int NOUT = 30,
  parameter int PWM_PIN = 22,
  parameter int SELW = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       st,
  input logic             sda_oe,
  input logic [NPINS-1:0] pin_oe,
  input logic [NPINS-1:0] pin_i,
  input logic [NPINS-1:0] in_s,
  input logic [SELW-1:0]  uart_sel_a,
  input logic [SELW-1:0]  uart_sel_b,
  input logic             pwm_en
);
  localparam logic [2:0] C_IDLE = 3'd0, C_RX = 3'd1, C_ACK = 3'd2, C_TX = 3'd3;

  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_IDLE) |-> !sda_oe); // R10
  AST_DRIVE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> (st == C_ACK || st == C_TX)); // R10
  AST_INPUT_PADS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    pin_oe[NPINS-1:NOUT] == '0); // R6
  AST_PWM_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    pwm_en |-> pin_oe[PWM_PIN]); // R8
  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st != C_RX) |=> ($stable(uart_sel_a) && $stable(uart_sel_b))); // R7
  AST_IN_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3) |-> (in_s == $past(pin_i, 2))); // R5
endmodule

bind i2c_gpio_bank i2c_gpio_bank_chk #(
  .NPINS(NPINS), .NOUT(NOUT), .PWM_PIN(PWM_PIN), .SELW(SELW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .st(st), .sda_oe(sda_oe), .pin_oe(pin_oe),
  .pin_i(pin_i), .in_s(in_s), .uart_sel_a(uart_sel_a),
  .uart_sel_b(uart_sel_b), .pwm_en(pwm_en)
);

// File: tb/tb_i2c_gpio_bank.sv
`timescale 1ns/1ps
module tb_i2c_gpio_bank;
  localparam int Q = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0;
  logic scl_drv = 1'b1, sda_drv = 1'b1;
  logic [43:0] pin_i = '0;
  logic pwm_i = 1'b0;
  logic sda_oe;
  logic [43:0] pin_o, pin_oe;
  logic [2:0] uart_sel_a, uart_sel_b;
  wire sda_line = sda_drv & ~sda_oe;
  bit glitch_en = 1'b0;

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  i2c_gpio_bank dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_drv), .sda_i(sda_line), .sda_oe(sda_oe),
    .pin_i(pin_i), .pin_o(pin_o), .pin_oe(pin_oe), .pwm_i(pwm_i),
    .uart_sel_a(uart_sel_a), .uart_sel_b(uart_sel_b)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    sda_drv = 1'b1; tick(Q);
    scl_drv = 1'b1; tick(2*Q);
    sda_drv = 1'b0; tick(2*Q);
    scl_drv = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_drv = 1'b0; tick(Q);
    scl_drv = 1'b1; tick(2*Q);
    sda_drv = 1'b1; tick(2*Q);
  endtask

  task automatic wbit(input logic b);
    tick(Q); sda_drv = b; tick(Q);
    scl_drv = 1'b1;
    if (glitch_en) begin
      tick(Q); sda_drv = ~b; tick(1); sda_drv = b; tick(Q-1);
    end else tick(2*Q);
    scl_drv = 1'b0;
  endtask

  task automatic rbit(output logic b);
    tick(Q); sda_drv = 1'b1; tick(Q);
    scl_drv = 1'b1; tick(Q);
    b = sda_line; tick(Q);
    scl_drv = 1'b0;
  endtask

  task automatic wbyte(input logic [7:0] d, output bit ack);
    logic a;
    for (int i = 7; i >= 0; i--) wbit(d[i]);
    rbit(a);
    ack = (a == 1'b0);
  endtask

  task automatic rbyte(input logic nack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) rbit(d[i]);
    wbit(nack);
  endtask

  task automatic reg_write(input logic [6:0] dev, input logic [15:0] a, input logic [7:0] d,
                           output bit all_ack);
    bit k;
    all_ack = 1'b1;
    bus_start();
    wbyte({dev, 1'b0}, k); all_ack &= k;
    wbyte(a[15:8], k);     all_ack &= k;
    wbyte(a[7:0], k);      all_ack &= k;
    wbyte(d, k);           all_ack &= k;
    bus_stop();
  endtask

  task automatic reg_read(input logic [15:0] a, output logic [7:0] d);
    bit k;
    bus_start();
    wbyte({7'h28, 1'b0}, k);
    wbyte(a[15:8], k);
    wbyte(a[7:0], k);
    bus_start();
    wbyte({7'h2B, 1'b1}, k);
    rbyte(1'b1, d);
    bus_stop();
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R10 reset pin_oe", pin_oe, 0);
    check("R10 reset pin_o", pin_o, 0);
    check("R10 reset sda_oe", sda_oe, 0);
    check("R7 reset sel_a", uart_sel_a, 0);
    check("R7 reset sel_b", uart_sel_b, 0);
    reg_read(16'd307, d);
    check("R7 reset readback 307", d, 8'h00);
  endtask

  task automatic t_addr_range();
    bit ok;
    for (int k = 0; k < 8; k++) begin
      reg_write(7'h28 + 7'(k), 16'(k), 8'h03, ok);
      check("R1 R2 acked in range", ok, 1);
      check("R4 pin_oe set", pin_oe[k], 1);
      check("R4 pin_o set", pin_o[k], 1);
    end
    bus_start(); wbyte({7'h27, 1'b0}, ok); bus_stop();
    check("R1 0x27 not acked", ok, 0);
    bus_start(); wbyte({7'h30, 1'b0}, ok); bus_stop();
    check("R1 0x30 not acked", ok, 0);
    check("R10 released after stop", sda_oe, 0);
  endtask

  task automatic t_pin_rw();
    bit ok;
    logic [7:0] d;
    reg_write(7'h28, 16'd5, 8'h01, ok);
    check("R4 pin5 oe", pin_oe[5], 1);
    check("R4 pin5 out", pin_o[5], 0);
    reg_read(16'd5, d);
    check("R3 R4 readback pin5", d, 8'h01);
    pin_i[5] = 1'b1;
    reg_read(16'd5, d);
    check("R5 input bit pin5", d, 8'h05);
    reg_write(7'h28, 16'd12, 8'hFA, ok);
    reg_read(16'd12, d);
    check("R5 reserved bits zero", d, 8'h02);
    check("R4 pin12 out", {pin_oe[12], pin_o[12]}, 2'b01);
  endtask

  task automatic t_input_pins();
    bit ok;
    logic [7:0] d;
    reg_write(7'h28, 16'd33, 8'h03, ok);
    check("R6 pin33 no enable", pin_oe[33], 0);
    check("R6 pin33 no drive", pin_o[33], 0);
    pin_i[33] = 1'b1;
    reg_read(16'd33, d);
    check("R6 pin33 readback", d, 8'h04);
    reg_write(7'h28, 16'd30, 8'h03, ok);
    reg_read(16'd30, d);
    check("R6 pin30 readback", d, 8'h00);
    check("R6 pin30 pads", {pin_oe[30], pin_o[30]}, 2'b00);
  endtask

  task automatic t_uart_sel();
    bit ok;
    logic [7:0] d;
    reg_write(7'h2C, 16'd307, 8'h05, ok);
    reg_write(7'h2F, 16'd308, 8'h06, ok);
    check("R7 sel_a", uart_sel_a, 3'd5);
    check("R7 sel_b", uart_sel_b, 3'd6);
    reg_read(16'd307, d);
    check("R3 R7 read 307", d, 8'h05);
    reg_read(16'd308, d);
    check("R3 R7 read 308", d, 8'h06);
  endtask

  task automatic t_pwm();
    bit ok;
    logic [7:0] d;
    reg_write(7'h28, 16'd22, 8'h00, ok);
    reg_write(7'h28, 16'd309, 8'h01, ok);
    pwm_i = 1'b1; tick(1);
    check("R8 pwm high", {pin_oe[22], pin_o[22]}, 2'b11);
    pwm_i = 1'b0; tick(1);
    check("R8 pwm low", {pin_oe[22], pin_o[22]}, 2'b10);
    reg_read(16'd309, d);
    check("R8 read 309", d, 8'h01);
    reg_write(7'h28, 16'd309, 8'h00, ok);
    pwm_i = 1'b1; tick(1);
    check("R8 pwm released", {pin_oe[22], pin_o[22]}, 2'b00);
  endtask

  task automatic t_undef();
    bit ok;
    logic [7:0] d;
    logic [43:0] oe0, o0;
    oe0 = pin_oe; o0 = pin_o;
    reg_write(7'h28, 16'd200, 8'hFF, ok);
    check("R9 undefined acked", ok, 1);
    reg_write(7'h28, 16'd310, 8'hFF, ok);
    reg_write(7'h28, 16'h012F + 16'h1000, 8'hFF, ok);
    check("R9 pads unchanged", {oe0, o0}, {pin_oe, pin_o});
    check("R9 selectors unchanged", {uart_sel_a, uart_sel_b}, 6'o56);
    reg_read(16'd200, d);
    check("R9 read 200", d, 8'h00);
    reg_read(16'd44, d);
    check("R9 read 44", d, 8'h00);
  endtask

  task automatic t_glitch();
    bit ok;
    logic [7:0] d;
    glitch_en = 1'b1;
    reg_write(7'h28, 16'd7, 8'h02, ok);
    glitch_en = 1'b0;
    check("R11 acked with glitches", ok, 1);
    check("R11 pin7", {pin_oe[7], pin_o[7]}, 2'b01);
    reg_read(16'd7, d);
    check("R11 read pin7", d, 8'h02);
  endtask

  initial begin
    tick(5);
    rst_n = 1'b1;
    tick(5);
    t_reset();
    t_addr_range();
    t_pin_rw();
    t_input_pins();
    t_uart_sel();
    t_pwm();
    t_undef();
    t_glitch();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_err++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule